// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the status word a host reads from a flash array while an embedded program or erase runs. The operation engine supplies the operation kind, its phase and a completion pulse. The address decoder reports whether the read address falls inside a block chosen for erase. The host supplies a read strobe. Two toggle flags let the host tell a working device from a stalled one. A polling bit reflects the data being written. A timeout flag latches the failure. A ready/busy output is driven low while the device works.

When the block has nothing to report, it asserts a data-select output, so the read path returns array contents instead of status. The status word is then all zero.

Phase encoding on `op_phase`: 0 = running, 1 = erase hold window, 2 = suspended, 3 = timed out. Status bit positions are fixed: bit 7 polling, bit 6 toggle, bit 5 timeout, bit 3 erase started, bit 2 erase-block toggle.

Top module: `emb_status_flags`

## Requirements
- R1: During an active program, status bit 7 reads the inverse of `prog_d7`. During an active erase, it reads 0.
- R2: Status bit 6 inverts after every falling edge of `rd_stb` while an operation is running, in its hold window, or timed out. It resets to 0.
- R3: Status bit 3 reads 0 in the erase hold window and 1 while an erase is running, suspended on a selected block, or timed out. It is always 0 for a program.
- R4: Status bit 2 inverts after each falling edge of `rd_stb` on a selected block (`sel_blk`=1) during an erase or an erase suspend. On unselected blocks during an active operation, and during any program, it reads a steady 1.
- R5: During an erase suspend with `sel_blk`=1, bit 7 reads 1, bit 3 reads 1, and bit 6 holds its value across reads.
- R6: While the phase is timed out, bit 5 reads 1 and the busy pattern locks. The lock persists even after `op_busy` falls, until a `sw_reset` pulse.
- R7: `rb_low` is 1 while an operation is running, in hold, or locked. It is 0 when idle or suspended.
- R8: Status bits 0, 1 and 4 always read 0. The whole status word is 0 whenever `data_sel` is 1.
- R9: `data_sel` is 1 when idle, during a program suspend, and during an erase suspend on an unselected block. Otherwise it is 0.
- R10: A `done_i` pulse, or a `sw_reset` pulse, clears both toggle flags, so the first reads of the next operation show 0 on bits 6 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_busy | input | 1 | Embedded operation in progress |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_phase | input | 2 | 0 run, 1 hold, 2 suspend, 3 timed out |
| sel_blk | input | 1 | Read address lies in a block selected for erase |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| rd_stb | input | 1 | Host read strobe, active high |
| done_i | input | 1 | Successful completion pulse |
| sw_reset | input | 1 | Reset command pulse |
| status | output | 8 | Status word |
| rb_low | output | 1 | 1 = drive ready/busy low, 0 = release it |
| data_sel | output | 1 | 1 = read path returns array data |

## Verification
The hardest state to reach is the timeout lock after the engine has already dropped `op_busy`. In that state the block must keep showing the busy pattern with live toggling, using only its latched state. The stimulus enters the timed-out phase for one cycle and then releases busy. It reads several times, checking that bit 6 keeps inverting and `rb_low` stays asserted, and then issues the reset command. Across the erase suspend sweep, the selected/unselected split is forced on the same bank state so that bit 2 toggling and bit 6 freezing are seen on alternate reads.

// File: rtl/emb_status_flags.sv
module emb_status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_busy,
  input  logic       op_erase,
  input  logic [1:0] op_phase,
  input  logic       sel_blk,
  input  logic       prog_d7,
  input  logic       rd_stb,
  input  logic       done_i,
  input  logic       sw_reset,
  output logic [7:0] status,
  output logic       rb_low,
  output logic       data_sel
);
  localparam logic [1:0] PH_RUN  = 2'd0;
  localparam logic [1:0] PH_HOLD = 2'd1;
  localparam logic [1:0] PH_SUSP = 2'd2;
  localparam logic [1:0] PH_TMO  = 2'd3;

  logic rd_q, tg6, tg2, lock_q;

  wire rd_fall  = rd_q & ~rd_stb;
  wire tmo      = lock_q | (op_busy & (op_phase == PH_TMO));
  wire susp     = op_busy & ~tmo & (op_phase == PH_SUSP);
  wire working  = (op_busy & ~susp) | tmo;
  wire esel_sus = susp & op_erase & sel_blk;
  wire en6      = rd_fall & working;
  wire en2      = rd_fall & op_erase & sel_blk & (working | susp);

  assign data_sel = ~working & ~esel_sus;
  assign rb_low   = working;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      lock_q <= 1'b0;
      tg6    <= 1'b0;
      tg2    <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (sw_reset)
        lock_q <= 1'b0;
      else if (op_busy && op_phase == PH_TMO)
        lock_q <= 1'b1;
      if (done_i || sw_reset) begin
        tg6 <= 1'b0;
        tg2 <= 1'b0;
      end else begin
        if (en6) tg6 <= ~tg6;
        if (en2) tg2 <= ~tg2;
      end
    end
  end

  always_comb begin
    status = 8'h00;
    if (working) begin
      status[7] = op_erase ? 1'b0 : ~prog_d7;
      status[6] = tg6;
      status[5] = tmo;
      status[3] = op_erase & (tmo | op_phase == PH_RUN);
      status[2] = (op_erase & sel_blk) ? tg2 : 1'b1;
    end else if (esel_sus) begin
      status[7] = 1'b1;
      status[6] = tg6;
      status[3] = 1'b1;
      status[2] = tg2;
    end
  end

  p_dq6_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && working && !done_i && !sw_reset) |=> (tg6 != $past(tg6)));

  p_dq6_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (esel_sus && !done_i && !sw_reset) |=> $stable(tg6));

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sw_reset) |=> lock_q);

  p_rb_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !lock_q) |-> !rb_low);

  p_zero_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == 2'b00) && !status[4] && (!data_sel || status == 8'h00));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (!tg6 && !tg2));
endmodule

// File: tb/emb_status_flags_tb.sv
module emb_status_flags_tb_top;
  logic clk = 0, rst_n = 0;
  logic op_busy = 0, op_erase = 0, sel_blk = 0, prog_d7 = 0, rd_stb = 0, done_i = 0, sw_reset = 0;
  logic [1:0] op_phase = 0;
  logic [7:0] status;
  logic rb_low, data_sel;
  int checks = 0, fails = 0;
  bit e6 = 0, e2 = 0, elock = 0;

  always #2 clk = ~clk;

  emb_status_flags dut_i (.clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .op_phase(op_phase), .sel_blk(sel_blk), .prog_d7(prog_d7), .rd_stb(rd_stb),
    .done_i(done_i), .sw_reset(sw_reset), .status(status), .rb_low(rb_low), .data_sel(data_sel));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit working();
    return (op_busy && op_phase != 2) || elock;
  endfunction

  function automatic bit esus();
    return !elock && op_busy && op_phase == 2 && op_erase && sel_blk;
  endfunction

  task automatic check_all();
    bit w = working();
    bit s = esus();
    logic [7:0] x = 8'h00;
    if (w) begin
      x[7] = op_erase ? 1'b0 : ~prog_d7;
      x[6] = e6;
      x[5] = elock;
      x[3] = op_erase && (elock || op_phase == 0);
      x[2] = (op_erase && sel_blk) ? e2 : 1'b1;
    end else if (s) begin
      x[7] = 1; x[6] = e6; x[3] = 1; x[2] = e2;
    end
    chk("R1 bit7", status[7], x[7]);
    chk(s ? "R5 bit6" : "R2 bit6", status[6], x[6]);
    chk("R6 bit5", status[5], x[5]);
    chk("R3 bit3", status[3], x[3]);
    chk("R4 bit2", status[2], x[2]);
    chk("R8 zero bits", {status[4], status[1:0]}, 0);
    chk("R7 rb_low", rb_low, w);
    chk("R9 data_sel", data_sel, !w && !s);
  endtask

  task automatic do_read();
    bit w, s;
    rd_stb = 1;
    @(posedge clk); #1;
    check_all();
    w = working();
    s = op_busy && op_phase == 2 && !elock;
    rd_stb = 0;
    @(posedge clk); #1;
    if (w) e6 = ~e6;
    if (op_erase && sel_blk && (w || s)) e2 = ~e2;
  endtask

  task automatic pulse_done();
    op_busy = 0; done_i = 1;
    @(posedge clk); #1;
    done_i = 0; e6 = 0; e2 = 0;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R8 reset status", status, 0);
    chk("R9 reset data_sel", data_sel, 1);
    chk("R7 reset rb_low", rb_low, 0);

    for (int er = 0; er < 2; er++)
      for (int ph = 0; ph < 3; ph++)
        for (int sb = 0; sb < 2; sb++)
          for (int d = 0; d < 2; d++) begin
            op_busy = 1; op_erase = er[0]; op_phase = ph[1:0]; sel_blk = sb[0]; prog_d7 = d[0];
            for (int k = 0; k < 3; k++) do_read();
            if (er == 1 && ph == 0) begin
              sel_blk = ~sel_blk;
              for (int k = 0; k < 2; k++) do_read();
            end
            pulse_done();
            chk("R10 cleared bit6", status[6], 0);
            chk("R9 idle data_sel", data_sel, 1);
          end

    // erase suspend: selected block toggles bit2, bit6 frozen
    op_busy = 1; op_erase = 1; op_phase = 0; sel_blk = 1;
    do_read(); do_read(); do_read();
    op_phase = 2;
    for (int k = 0; k < 4; k++) begin sel_blk = k[0]; do_read(); end
    op_phase = 0;
    do_read();
    pulse_done();
    op_busy = 1; sel_blk = 1;
    rd_stb = 1; @(posedge clk); #1;
    chk("R10 first read bit6", status[6], 0);
    chk("R10 first read bit2", status[2], 0);
    rd_stb = 0; @(posedge clk); #1; e6 = 1; e2 = 1;

    // timeout lock
    op_phase = 3;
    @(posedge clk); #1; elock = 1;
    do_read();
    op_busy = 0; op_phase = 0;
    for (int k = 0; k < 3; k++) do_read();
    chk("R6 lock after busy drop", rb_low, 1);
    sw_reset = 1; @(posedge clk); #1; sw_reset = 0;
    elock = 0; e6 = 0; e2 = 0;
    check_all();
    chk("R6 released status", status, 0);

    // program timeout
    op_busy = 1; op_erase = 0; op_phase = 3; prog_d7 = 1;
    @(posedge clk); #1; elock = 1;
    do_read(); do_read();
    op_busy = 0;
    do_read();
    sw_reset = 1; @(posedge clk); #1; sw_reset = 0;
    elock = 0; e6 = 0; e2 = 0;
    check_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule